// File: doc/BRIEF.md
# ADC Window Watchdog Comparator

This block watches the stream of converted samples leaving an analog-to-digital converter and decides whether each one lies inside a programmable window bounded by a lower and an upper 12-bit limit. Each sample comes with a valid strobe, a 5-bit channel number and a one-bit group tag, which says whether the conversion belongs to the regular group or to the inserted group. Checking can be switched on for each group on its own. It can also be narrowed to a single selected channel, so that samples from other channels pass unchecked.

When a checked sample falls outside the window, a sticky event flag is set. The flag stays set until the clear input is pulsed. An interrupt request follows the flag, gated by an interrupt enable. All settings arrive as plain register-style inputs. The comparison works on the 12-bit right-justified sample value, so the way the data is later aligned for software does not affect it.

Top module: `adc_window_watchdog`

## Requirements
- R1: After reset is asserted, wd_flag and wd_irq are both 0.
- R2: A checked sample strictly greater than cfg_high sets wd_flag at the clock edge that samples it. A sample equal to cfg_high does not set it.
- R3: A checked sample strictly less than cfg_low sets wd_flag at the clock edge that samples it. A sample equal to cfg_low does not set it.
- R4: sample_group 0 marks a regular sample and is checked only while cfg_reg_en is 1. sample_group 1 marks an inserted sample and is checked only while cfg_ins_en is 1. The two enables act independently.
- R5: While cfg_single is 1, only samples whose sample_chan equals cfg_chan_sel are checked. While cfg_single is 0, samples on every valid channel from 0 to 18 are checked.
- R6: Samples with sample_chan from 19 to 31 are never checked, in either channel mode.
- R7: A cycle in which sample_valid is 0 never sets wd_flag, whatever the other sample inputs hold.
- R8: Once set, wd_flag stays 1 through any number of in-window or unchecked samples. A cycle with flag_clr at 1 and no new event clears it at that edge.
- R9: If flag_clr is 1 in the same cycle as an out-of-window checked sample, wd_flag is 1 after that edge.
- R10: wd_irq is a register. At each clock edge it loads the new value of wd_flag ANDed with cfg_irq_en, so changing cfg_irq_en while the flag is set moves wd_irq one edge later.
- R11: When cfg_low is greater than cfg_high, every checked sample is out of window and sets wd_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | Sample strobe |
| sample_group | input | 1 | 0 = regular group, 1 = inserted group |
| sample_chan | input | 5 | Channel number of the sample |
| sample_data | input | 12 | Right-justified conversion result |
| cfg_low | input | 12 | Lower window limit (inclusive) |
| cfg_high | input | 12 | Upper window limit (inclusive) |
| cfg_reg_en | input | 1 | Check regular-group samples |
| cfg_ins_en | input | 1 | Check inserted-group samples |
| cfg_single | input | 1 | Restrict checking to one channel |
| cfg_chan_sel | input | 5 | Channel checked in single-channel mode |
| cfg_irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear pulse for the event flag |
| wd_flag | output | 1 | Sticky out-of-window event flag |
| wd_irq | output | 1 | Interrupt request |

## Verification
The hardest situation to bring about is a clear pulse that lands in the very cycle of a new out-of-window sample. The flag must already be set, and the new event has to win. The bench first raises the flag with one excursion and checks that in-window traffic leaves it set. It then drives flag_clr and a second excursion on the same falling edge, so both are seen at one rising edge. Behaviour at the exact limits, the inverted window and channel numbers past the valid range each come from vectors in a table. Before each vector the flag is cleared, so every vector's result comes from that vector alone.

// File: rtl/adcwd_pkg.sv
package adcwd_pkg;

    // Group tag carried with every sample
    typedef enum logic {
        GRP_REGULAR  = 1'b0,
        GRP_INSERTED = 1'b1
    } conv_group_e;

    // Registered state of the event logic
    typedef struct packed {
        logic flag;
        logic irq;
    } wd_state_t;

endpackage

// File: rtl/adcwd_qualify.sv
module adcwd_qualify
    import adcwd_pkg::*;
#(
    parameter int CHAN_W   = 5,
    parameter int MAX_CHAN = 18
) (
    input  logic              sample_valid,
    input  logic              sample_group,
    input  logic [CHAN_W-1:0] sample_chan,
    input  logic              cfg_reg_en,
    input  logic              cfg_ins_en,
    input  logic              cfg_single,
    input  logic [CHAN_W-1:0] cfg_chan_sel,
    output logic              check
);
    localparam logic [CHAN_W-1:0] LAST_CHAN = CHAN_W'(MAX_CHAN);

    logic group_ok;
    logic chan_ok;
    logic in_range;

    always_comb begin
        in_range = (sample_chan <= LAST_CHAN);
        unique case (conv_group_e'(sample_group))
            GRP_REGULAR:  group_ok = cfg_reg_en;
            GRP_INSERTED: group_ok = cfg_ins_en;
            default:      group_ok = 1'b0;
        endcase
        chan_ok = cfg_single ? (sample_chan == cfg_chan_sel) : 1'b1;
        check   = sample_valid & group_ok & chan_ok & in_range;
    end

endmodule

// File: rtl/adcwd_window.sv
module adcwd_window #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] sample_data,
    input  logic [DATA_W-1:0] cfg_low,
    input  logic [DATA_W-1:0] cfg_high,
    output logic              outside
);
    logic above;
    logic below;

    always_comb begin
        above   = (sample_data > cfg_high);
        below   = (sample_data < cfg_low);
        outside = above | below;
    end

endmodule

// File: rtl/adcwd_flag.sv
module adcwd_flag
    import adcwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_hit,
    input  logic flag_clr,
    input  logic cfg_irq_en,
    output logic flag,
    output logic irq
);
    wd_state_t st_d;
    wd_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (event_hit) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
        st_d.irq = st_d.flag & cfg_irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign irq  = st_q.irq;

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    // R8
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !event_hit) |=> !flag);

    // R9
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        event_hit |=> flag);

    // R10
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (event_hit && cfg_irq_en) |=> irq);

endmodule

// File: rtl/adc_window_watchdog.sv
module adc_window_watchdog #(
    parameter int DATA_W   = 12,
    parameter int CHAN_W   = 5,
    parameter int MAX_CHAN = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic              sample_group,
    input  logic [CHAN_W-1:0] sample_chan,
    input  logic [DATA_W-1:0] sample_data,
    input  logic [DATA_W-1:0] cfg_low,
    input  logic [DATA_W-1:0] cfg_high,
    input  logic              cfg_reg_en,
    input  logic              cfg_ins_en,
    input  logic              cfg_single,
    input  logic [CHAN_W-1:0] cfg_chan_sel,
    input  logic              cfg_irq_en,
    input  logic              flag_clr,
    output logic              wd_flag,
    output logic              wd_irq
);
    localparam logic [CHAN_W-1:0] LAST_CHAN = CHAN_W'(MAX_CHAN);

    logic check;
    logic outside;
    logic event_hit;

    adcwd_qualify #(
        .CHAN_W  (CHAN_W),
        .MAX_CHAN(MAX_CHAN)
    ) u_qualify (
        .sample_valid(sample_valid),
        .sample_group(sample_group),
        .sample_chan (sample_chan),
        .cfg_reg_en  (cfg_reg_en),
        .cfg_ins_en  (cfg_ins_en),
        .cfg_single  (cfg_single),
        .cfg_chan_sel(cfg_chan_sel),
        .check       (check)
    );

    adcwd_window #(
        .DATA_W(DATA_W)
    ) u_window (
        .sample_data(sample_data),
        .cfg_low    (cfg_low),
        .cfg_high   (cfg_high),
        .outside    (outside)
    );

    assign event_hit = check & outside;

    adcwd_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_hit (event_hit),
        .flag_clr  (flag_clr),
        .cfg_irq_en(cfg_irq_en),
        .flag      (wd_flag),
        .irq       (wd_irq)
    );

    // R7
    rise_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_flag && !sample_valid) |=> !wd_flag);

    // R6
    bad_chan_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_flag && sample_chan > LAST_CHAN) |=> !wd_flag);

    // R2
    inside_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_flag && sample_data <= cfg_high && sample_data >= cfg_low) |=> !wd_flag);

endmodule

// File: tb/adc_window_watchdog_test.sv
module adc_window_watchdog_test;

    typedef struct packed {
        logic [3:0]  req;
        logic        reg_en;
        logic        ins_en;
        logic        single;
        logic [4:0]  sel;
        logic        irq_en;
        logic [11:0] low;
        logic [11:0] high;
        logic        grp;
        logic [4:0]  chan;
        logic [11:0] data;
        logic        exp_flag;
        logic        exp_irq;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        // R2: above high / equal to high
        '{4'd2,  1'b1,1'b0,1'b0,5'd0, 1'b1,12'h100,12'hC00,1'b0,5'd3, 12'hC01,1'b1,1'b1},
        '{4'd2,  1'b1,1'b0,1'b0,5'd0, 1'b1,12'h100,12'hC00,1'b0,5'd3, 12'hC00,1'b0,1'b0},
        // R3: equal to low / below low (irq disabled)
        '{4'd3,  1'b1,1'b0,1'b0,5'd0, 1'b1,12'h100,12'hC00,1'b0,5'd3, 12'h100,1'b0,1'b0},
        '{4'd3,  1'b1,1'b0,1'b0,5'd0, 1'b0,12'h100,12'hC00,1'b0,5'd3, 12'h0FF,1'b1,1'b0},
        // R4: group enables
        '{4'd4,  1'b1,1'b0,1'b0,5'd0, 1'b1,12'h100,12'hC00,1'b1,5'd3, 12'hFFF,1'b0,1'b0},
        '{4'd4,  1'b0,1'b1,1'b0,5'd0, 1'b1,12'h100,12'hC00,1'b1,5'd3, 12'hFFF,1'b1,1'b1},
        '{4'd4,  1'b0,1'b1,1'b0,5'd0, 1'b1,12'h100,12'hC00,1'b0,5'd3, 12'hFFF,1'b0,1'b0},
        '{4'd4,  1'b0,1'b0,1'b0,5'd0, 1'b1,12'h100,12'hC00,1'b0,5'd3, 12'h000,1'b0,1'b0},
        // R5: single channel mode
        '{4'd5,  1'b1,1'b1,1'b1,5'd5, 1'b1,12'h100,12'hC00,1'b0,5'd5, 12'h000,1'b1,1'b1},
        '{4'd5,  1'b1,1'b1,1'b1,5'd5, 1'b1,12'h100,12'hC00,1'b0,5'd6, 12'h000,1'b0,1'b0},
        '{4'd5,  1'b1,1'b1,1'b0,5'd5, 1'b1,12'h100,12'hC00,1'b1,5'd18,12'h000,1'b1,1'b1},
        '{4'd5,  1'b1,1'b1,1'b0,5'd5, 1'b1,12'h100,12'hC00,1'b0,5'd0, 12'hFFF,1'b1,1'b1},
        // R6: channels past 18
        '{4'd6,  1'b1,1'b1,1'b0,5'd0, 1'b1,12'h100,12'hC00,1'b0,5'd19,12'h000,1'b0,1'b0},
        '{4'd6,  1'b1,1'b1,1'b0,5'd0, 1'b1,12'h100,12'hC00,1'b1,5'd31,12'hFFF,1'b0,1'b0},
        '{4'd6,  1'b1,1'b1,1'b1,5'd19,1'b1,12'h100,12'hC00,1'b0,5'd19,12'hFFF,1'b0,1'b0},
        // R11: inverted window
        '{4'd11, 1'b1,1'b0,1'b0,5'd0, 1'b1,12'h800,12'h700,1'b0,5'd1, 12'h780,1'b1,1'b1},
        '{4'd11, 1'b1,1'b0,1'b0,5'd0, 1'b1,12'h800,12'h700,1'b0,5'd1, 12'h800,1'b1,1'b1},
        // R2 / R3: full-range window never fires
        '{4'd2,  1'b1,1'b0,1'b0,5'd0, 1'b1,12'h000,12'hFFF,1'b0,5'd2, 12'hFFF,1'b0,1'b0},
        '{4'd3,  1'b1,1'b0,1'b0,5'd0, 1'b1,12'h000,12'hFFF,1'b0,5'd2, 12'h000,1'b0,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic        sample_group = 1'b0;
    logic [4:0]  sample_chan = '0;
    logic [11:0] sample_data = '0;
    logic [11:0] cfg_low = '0;
    logic [11:0] cfg_high = 12'hFFF;
    logic        cfg_reg_en = 1'b0;
    logic        cfg_ins_en = 1'b0;
    logic        cfg_single = 1'b0;
    logic [4:0]  cfg_chan_sel = '0;
    logic        cfg_irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        wd_flag;
    logic        wd_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adc_window_watchdog uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_valid(sample_valid),
        .sample_group(sample_group),
        .sample_chan (sample_chan),
        .sample_data (sample_data),
        .cfg_low     (cfg_low),
        .cfg_high    (cfg_high),
        .cfg_reg_en  (cfg_reg_en),
        .cfg_ins_en  (cfg_ins_en),
        .cfg_single  (cfg_single),
        .cfg_chan_sel(cfg_chan_sel),
        .cfg_irq_en  (cfg_irq_en),
        .flag_clr    (flag_clr),
        .wd_flag     (wd_flag),
        .wd_irq      (wd_irq)
    );

    task automatic check(input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", what, got, exp);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk);
        sample_valid = 1'b0;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic send(input logic grp, input logic [4:0] ch, input logic [11:0] d);
        sample_valid = 1'b1;
        sample_group = grp;
        sample_chan  = ch;
        sample_data  = d;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check(wd_flag, 1'b0, "R1 flag in reset");
        check(wd_irq, 1'b0, "R1 irq in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(wd_flag, 1'b0, "R1 flag after reset");

        for (int i = 0; i < NVEC; i++) begin
            clear_flag();
            cfg_reg_en   = VECS[i].reg_en;
            cfg_ins_en   = VECS[i].ins_en;
            cfg_single   = VECS[i].single;
            cfg_chan_sel = VECS[i].sel;
            cfg_irq_en   = VECS[i].irq_en;
            cfg_low      = VECS[i].low;
            cfg_high     = VECS[i].high;
            send(VECS[i].grp, VECS[i].chan, VECS[i].data);
            check(wd_flag, VECS[i].exp_flag, $sformatf("R%0d vec %0d flag", VECS[i].req, i));
            check(wd_irq, VECS[i].exp_irq, $sformatf("R%0d vec %0d irq", VECS[i].req, i));
        end

        // common setting for directed tests
        cfg_reg_en = 1'b1; cfg_ins_en = 1'b1; cfg_single = 1'b0;
        cfg_low = 12'h100; cfg_high = 12'hC00; cfg_irq_en = 1'b0;

        // R7: out-of-window data with no strobe
        clear_flag();
        sample_group = 1'b0; sample_chan = 5'd4; sample_data = 12'hFFF;
        repeat (3) @(negedge clk);
        check(wd_flag, 1'b0, "R7 data without valid");

        // R8: sticky through in-window and unchecked traffic
        send(1'b0, 5'd4, 12'hFFF);
        check(wd_flag, 1'b1, "R8 flag set");
        send(1'b0, 5'd4, 12'h500);
        send(1'b1, 5'd20, 12'hFFF);
        send(1'b0, 5'd7, 12'h100);
        check(wd_flag, 1'b1, "R8 flag held");

        // R10: irq follows enable one edge later
        check(wd_irq, 1'b0, "R10 irq gated off");
        cfg_irq_en = 1'b1;
        @(negedge clk);
        check(wd_irq, 1'b1, "R10 irq after enable");
        cfg_irq_en = 1'b0;
        @(negedge clk);
        check(wd_irq, 1'b0, "R10 irq after disable");
        check(wd_flag, 1'b1, "R10 flag unaffected by irq enable");

        // R9: clear and new event in the same cycle
        flag_clr = 1'b1;
        send(1'b1, 5'd2, 12'h050);
        flag_clr = 1'b0;
        check(wd_flag, 1'b1, "R9 event beats clear");

        // R8: plain clear
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(wd_flag, 1'b0, "R8 flag cleared");
        @(negedge clk);
        check(wd_flag, 1'b0, "R8 stays clear");

        // R1: reset mid-run clears flag
        send(1'b0, 5'd1, 12'hFFF);
        rst_n = 1'b0;
        @(negedge clk);
        check(wd_flag, 1'b0, "R1 flag on reset");
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule